// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a management-bus master for PHY devices. Software issues a single register read or write by programming one packed access word; the block generates the management clock from the system clock through a programmable divider, serialises a clause-22 frame on the data line, and, for a read, places the 16 returned bits back into the same word. The top bit of that word serves two purposes: writing it as 1 starts the transaction, and reading it as 1 means the transaction is still running.

A second, smaller register holds the block enable, the clock divider and a read-only idle flag. Software normally enables the block and picks a divider that yields a management clock near 2.2 MHz. It then writes the access word and polls until the top bit reads back as 0. Only one transaction is in flight at a time.

The block sits behind a minimal register port. A single address bit selects between the control word (0) and the access word (1). Writes take effect on the clock edge, and reads are combinational.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control word reads 0x8000_0000 (idle 1, enable 0, divider 0), the access word reads 0, and `mdc` and `mdio_oe` are low.
- R2: Writing the access word with bit 31 set while the block is enabled and idle makes bit 31 read back as 1 on the following cycle. Bit 31 stays 1 until the frame's last bit has been clocked, then returns to 0.
- R3: Each frame contains 64 bits, sent MSB first and valid at `mdc` rising edges, in this order: 32 ones; start 01; opcode (10 for read when access bit 30 is 0, 01 for write when it is 1); the 5-bit PHY address from access bits 20:16; the 5-bit register address from access bits 25:21; a 2-bit turnaround; 16 data bits.
- R4: In a write frame `mdio_oe` is high for all 64 bits, the turnaround is driven as 10, and the data bits come from access bits 15:0.
- R5: In a read frame `mdio_oe` is low for the final 18 bits (turnaround and data). `mdio_i` is sampled at each `mdc` rising edge of the data phase. Once bit 31 clears, access bits 15:0 hold the sampled word, first bit in bit 15, and bits 30:16 are unchanged.
- R6: While enabled, `mdc` has a period of D+1 system clocks, where D is control bits 7:0 and a value of 0 behaves as 1. Within each period `mdc` is high for D+1-floor((D+1)/2) clocks.
- R7: A write to the access word while bit 31 reads 1 is ignored. The readback is unchanged and the frame in progress continues with its original content.
- R8: With enable (control bit 30) low, `mdc` stays low, control bit 31 reads 1, and writing the access word with bit 31 set stores the other fields but leaves bit 31 at 0.
- R9: Clearing enable during a frame aborts it. Bit 31 of the access word returns to 0, idle reads 1, and `mdio_oe` and `mdc` go low.
- R10: While enabled, control bit 31 (idle) always reads as the inverse of access bit 31.
- R11: An access-word write with bit 31 clear stores the fields without starting a frame, so `mdio_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 control word, 1 access word |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The assertions rest on a few assumptions. The divider is changed only while no access is running, the register port is used only at its two addresses, and `mdio_i` stays stable between the falling and rising `mdc` edges of each read bit. The stimulus honours all three. The bench writes the control word only before it arms an access, or deliberately in order to abort one, and its PHY model updates `mdio_i` right after it observes each rising `mdc` edge, a full system clock before the next one. Random transactions vary direction, addresses, data and divider, and directed cases cover divider 0, divider 255, a write while busy, a go bit while disabled, and a mid-frame abort.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned FIELD_W   = 5;
   localparam int unsigned DATA_W    = 16;

   localparam int unsigned CTL_IDLE  = 31;
   localparam int unsigned CTL_EN    = 30;
   localparam int unsigned ACC_GO    = 31;
   localparam int unsigned ACC_WR    = 30;

   localparam logic [1:0] ST_CODE    = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] TA_WRITE   = 2'b10;

   typedef struct packed {
      logic               go;
      logic               wr;
      logic [3:0]         rsvd;
      logic [FIELD_W-1:0] regad;
      logic [FIELD_W-1:0] phyad;
      logic [DATA_W-1:0]  data;
   } acc_word_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_p,
   output logic             fall_p
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] cnt_nxt;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W:0]   half_pt;
   logic             mdc_q;

   always_comb begin
      div_eff = (div == '0) ? DIV_W'(1) : div;
      half_pt = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;
      cnt_nxt = (cnt_q >= div_eff) ? '0 : cnt_q + 1'b1;
   end

   assign rise_p = en && ({1'b0, cnt_nxt} == half_pt);
   assign fall_p = en && (cnt_nxt == '0);
   assign mdc    = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         mdc_q <= ({1'b0, cnt_nxt} >= half_pt);
      end
   end

   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_p && fall_p));
   assert_rise_sets_mdc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_p |=> mdc_q);
   assert_fall_clears_mdc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fall_p |=> !mdc_q);
   assert_mdc_low_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !mdc_q);

endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES == 0) begin : g_direct
      logic unused_sync;
      assign unused_sync = clk ^ rst_n;
      assign dout = din;
   end else begin : g_flops
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '1;
         else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], din};
      end
      assign dout = chain_q[STAGES-1];
   end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               start,
   input  logic               start_wr,
   input  logic [FIELD_W-1:0] start_phy,
   input  logic [FIELD_W-1:0] start_reg,
   input  logic [DATA_W-1:0]  start_data,
   input  logic               rise_p,
   input  logic               fall_p,
   input  logic               mdio_in,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               done,
   output logic [DATA_W-1:0]  rx_data
);

   localparam int unsigned FRAME_LEN = PRE_LEN + 32;
   localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
   localparam int unsigned LAST      = FRAME_LEN - 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LAST);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
   localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_LEN + 16);

   logic                 pending_q;
   logic                 launched_q;
   logic                 is_rd_q;
   logic [IDX_W-1:0]     idx_q;
   logic [IDX_W-1:0]     idx_nxt;
   logic [FRAME_LEN-1:0] sh_q;
   logic [FRAME_LEN-1:0] frame_word;
   logic [DATA_W-1:0]    rx_q;
   logic                 out_q;
   logic                 oe_q;
   logic                 drive_nxt;

   always_comb begin
      frame_word = {{PRE_LEN{1'b1}}, ST_CODE,
                    start_wr ? OP_WRITE : OP_READ,
                    start_phy, start_reg,
                    start_wr ? TA_WRITE : 2'b11,
                    start_wr ? start_data : {DATA_W{1'b1}}};
      idx_nxt   = idx_q + IDX_W'(1);
      drive_nxt = !(is_rd_q && (idx_nxt >= TA_IDX));
   end

   assign done    = en && launched_q && fall_p && (idx_q == LAST_IDX);
   assign mdio_o  = out_q;
   assign mdio_oe = oe_q;
   assign rx_data = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q  <= 1'b0;
         launched_q <= 1'b0;
         is_rd_q    <= 1'b0;
         idx_q      <= '0;
         sh_q       <= '0;
         rx_q       <= '0;
         out_q      <= 1'b0;
         oe_q       <= 1'b0;
      end else if (!en) begin
         pending_q  <= 1'b0;
         launched_q <= 1'b0;
         out_q      <= 1'b0;
         oe_q       <= 1'b0;
      end else begin
         if (start) begin
            pending_q <= 1'b1;
            is_rd_q   <= !start_wr;
            sh_q      <= frame_word;
            rx_q      <= '0;
         end else if (fall_p) begin
            if (pending_q && !launched_q) begin
               pending_q  <= 1'b0;
               launched_q <= 1'b1;
               idx_q      <= '0;
               out_q      <= sh_q[LAST];
               oe_q       <= 1'b1;
               sh_q       <= {sh_q[LAST-1:0], 1'b0};
            end else if (launched_q && (idx_q != LAST_IDX)) begin
               idx_q <= idx_nxt;
               out_q <= sh_q[LAST];
               oe_q  <= drive_nxt;
               sh_q  <= {sh_q[LAST-1:0], 1'b0};
            end else if (launched_q) begin
               launched_q <= 1'b0;
               out_q      <= 1'b0;
               oe_q       <= 1'b0;
            end
         end
         if (rise_p && launched_q && is_rd_q && (idx_q >= DATA_IDX)) begin
            rx_q <= {rx_q[DATA_W-2:0], mdio_in};
         end
      end
   end

   assert_ta_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (launched_q && is_rd_q && (idx_q >= TA_IDX)) |-> !oe_q);
   assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (launched_q && !is_rd_q) |-> oe_q);
   assert_no_start_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_q || launched_q) |-> !start);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned PRE_LEN = 32,
   parameter int unsigned IN_SYNC = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_addr,
   input  logic        bus_wr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);

   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN must lie in 1..64");
   end
   if (IN_SYNC > 3) begin : g_bad_sync
      $error("IN_SYNC must lie in 0..3");
   end

   logic             ctrl_en_q;
   logic [DIV_W-1:0] ctrl_div_q;
   acc_word_t        acc_q;
   logic             acc_wr_ok;
   logic             go_ok;
   logic             ctrl_wr;
   logic             rise_p;
   logic             fall_p;
   logic             eng_done;
   logic [DATA_W-1:0] eng_rx;
   logic             mdio_in_s;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata[29:26];
   assign ctrl_wr   = bus_wr && !bus_addr;
   assign acc_wr_ok = bus_wr && bus_addr && !acc_q.go;
   assign go_ok     = acc_wr_ok && bus_wdata[ACC_GO] && ctrl_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en_q  <= 1'b0;
         ctrl_div_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_en_q  <= bus_wdata[CTL_EN];
         ctrl_div_q <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         if (acc_wr_ok) begin
            acc_q.go    <= go_ok;
            acc_q.wr    <= bus_wdata[ACC_WR];
            acc_q.rsvd  <= '0;
            acc_q.regad <= bus_wdata[25:21];
            acc_q.phyad <= bus_wdata[20:16];
            acc_q.data  <= bus_wdata[15:0];
         end else if (eng_done) begin
            acc_q.go <= 1'b0;
            if (!acc_q.wr) acc_q.data <= eng_rx;
         end
         if (!ctrl_en_q) acc_q.go <= 1'b0;
      end
   end

   always_comb begin
      if (bus_addr) bus_rdata = acc_q;
      else          bus_rdata = {~acc_q.go, ctrl_en_q, {(30-DIV_W){1'b0}}, ctrl_div_q};
   end

   mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_en_q),
      .div    (ctrl_div_q),
      .mdc    (mdc),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   mdio_in_sync #(.STAGES(IN_SYNC)) in_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (mdio_i),
      .dout  (mdio_in_s)
   );

   mdio_frame_eng #(.PRE_LEN(PRE_LEN)) frame_eng_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl_en_q),
      .start      (go_ok),
      .start_wr   (bus_wdata[ACC_WR]),
      .start_phy  (bus_wdata[20:16]),
      .start_reg  (bus_wdata[25:21]),
      .start_data (bus_wdata[15:0]),
      .rise_p     (rise_p),
      .fall_p     (fall_p),
      .mdio_in    (mdio_in_s),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .done       (eng_done),
      .rx_data    (eng_rx)
   );

   assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q.go && ctrl_en_q && !eng_done) |=> acc_q.go);
   assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> !acc_q.go);
   assert_ignore_busy_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q.go && ctrl_en_q && !eng_done && bus_wr && bus_addr) |=> $stable(acc_q));
   assert_oe_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_q.go |-> !mdio_oe);
   assert_go_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en_q |=> !acc_q.go);

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int total = 0;
   int fails = 0;
   bit finished = 0;
   longint cyc = 0;

   mdio_mgmt_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // PHY model and frame recorder
   int          arm_id = 0;
   int          seen_arm = 0;
   int          rcnt = 0;
   logic [63:0] got_o = '0, got_oe = '0;
   logic [15:0] exp_rd = '0;
   int          exp_per = 2, exp_hi = 1;
   int          per_bad = 0;
   longint      last_rise = -1;
   logic        prev_mdc = 1'b0;

   always @(negedge clk) begin
      if (arm_id != seen_arm) begin
         seen_arm = arm_id; rcnt = 0; got_o = '0; got_oe = '0;
         per_bad = 0; last_rise = -1;
      end
      if (mdc && !prev_mdc) begin
         if (rcnt > 0 && last_rise >= 0 && (cyc - last_rise) != longint'(exp_per)) per_bad++;
         if (!(rcnt == 0 && !mdio_oe) && rcnt < FRAME) begin
            got_o[63-rcnt]  = mdio_o;
            got_oe[63-rcnt] = mdio_oe;
            rcnt++;
         end
         last_rise = cyc;
      end
      if (!mdc && prev_mdc && rcnt > 0 && rcnt < FRAME && last_rise >= 0 &&
          (cyc - last_rise) != longint'(exp_hi)) per_bad++;
      prev_mdc = mdc;
      if (rcnt >= 48 && rcnt < FRAME) mdio_i = exp_rd[63-rcnt];
      else mdio_i = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] phy,
                                             input logic [4:0] rg, input logic [15:0] dat);
      return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, rg,
              wr ? 2'b10 : 2'b00, wr ? dat : 16'h0};
   endfunction

   task automatic run_access(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] dat, input logic [15:0] rdv,
                             input logic [7:0] dv, input bit inject);
      logic [31:0] word, rb, rc;
      logic [63:0] ef, mask;
      int deff, waited;
      deff = (dv == 0) ? 1 : int'(dv);
      exp_rd = rdv; exp_per = deff + 1; exp_hi = deff + 1 - (deff + 1) / 2;
      bus_write(1'b0, {1'b0, 1'b1, 22'b0, dv});
      arm_id++;
      word = {1'b1, wr, 4'b0, rg, phy, dat};
      bus_write(1'b1, word);
      bus_read(1'b1, rb);
      chk(rb == word, "R2 busy set after go", 64'(rb), 64'(word));
      bus_read(1'b0, rc);
      chk(rc[31] == 1'b0, "R10 idle low while busy", 64'(rc[31]), 64'd0);
      if (inject) begin
         repeat (30) @(negedge clk);
         bus_write(1'b1, ~word | 32'h8000_0000);
         bus_read(1'b1, rb);
         chk(rb == word, "R7 write while busy ignored", 64'(rb), 64'(word));
      end
      waited = 0;
      rb = 32'h8000_0000;
      while (rb[31] && waited < 40000) begin
         bus_read(1'b1, rb);
         waited++;
      end
      chk(rcnt == FRAME, "R3 bit count", 64'(rcnt), 64'(FRAME));
      ef = exp_frame(wr, phy, rg, dat);
      mask = wr ? '1 : ~64'h3FFFF;
      chk(got_oe == mask, wr ? "R4 oe pattern" : "R5 oe pattern", got_oe, mask);
      chk((got_o & mask) == (ef & mask), "R3 frame bits", got_o & mask, ef & mask);
      chk(per_bad == 0, "R6 mdc period and high time", 64'(per_bad), 64'd0);
      if (wr) chk(rb == {1'b0, word[30:0]}, "R2 busy cleared after write", 64'(rb), 64'({1'b0, word[30:0]}));
      else    chk(rb == {1'b0, 1'b0, 4'b0, rg, phy, rdv}, "R5 read data returned",
                  64'(rb), 64'({1'b0, 1'b0, 4'b0, rg, phy, rdv}));
      bus_read(1'b0, rc);
      chk(rc[31] == 1'b1, "R10 idle after completion", 64'(rc[31]), 64'd1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] rb;
      int highs, oes;
      int unsigned seed;
      seed = $urandom(32'h1357);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(1'b0, rb);
      chk(rb == 32'h8000_0000, "R1 control reset", 64'(rb), 64'h8000_0000);
      bus_read(1'b1, rb);
      chk(rb == 32'h0, "R1 access reset", 64'(rb), 64'h0);
      chk(!mdc && !mdio_oe, "R1 pins low", 64'({mdc, mdio_oe}), 64'd0);

      // R8 disabled: go ignored, mdc quiet
      bus_write(1'b1, 32'hC0A5_1234);
      highs = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (mdc || mdio_oe) highs++; end
      bus_read(1'b1, rb);
      chk(rb == 32'h40A5_1234, "R8 go ignored when disabled", 64'(rb), 64'h40A5_1234);
      chk(highs == 0, "R8 mdc held low", 64'(highs), 64'd0);
      bus_read(1'b0, rb);
      chk(rb[31] == 1'b1, "R8 idle reads 1", 64'(rb[31]), 64'd1);

      // R11 store without go
      bus_write(1'b0, 32'h4000_0002);
      bus_write(1'b1, 32'h0123_BEEF);
      oes = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (mdio_oe) oes++; end
      bus_read(1'b1, rb);
      chk(rb == 32'h0123_BEEF, "R11 fields stored", 64'(rb), 64'h0123_BEEF);
      chk(oes == 0, "R11 no frame", 64'(oes), 64'd0);

      // directed
      run_access(1'b1, 5'h1F, 5'h00, 16'hA55A, 16'h0, 8'd0, 1'b0);
      run_access(1'b0, 5'h00, 5'h1F, 16'h0, 16'h8001, 8'd1, 1'b0);
      run_access(1'b1, 5'h0A, 5'h15, 16'h1234, 16'h0, 8'd4, 1'b1);
      run_access(1'b0, 5'h11, 5'h02, 16'h0, 16'hC3F0, 8'd255, 1'b0);

      // random
      for (int n = 0; n < 10; n++) begin
         run_access(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), 8'($urandom_range(1, 6)), 1'b0);
      end

      // R9 abort mid-frame
      bus_write(1'b0, 32'h4000_0003);
      bus_write(1'b1, 32'h8000_FFFF);
      repeat (100) @(negedge clk);
      bus_write(1'b0, 32'h0000_0003);
      repeat (2) @(negedge clk);
      bus_read(1'b1, rb);
      chk(rb[31] == 1'b0, "R9 busy cleared by abort", 64'(rb[31]), 64'd0);
      bus_read(1'b0, rb);
      chk(rb[31] == 1'b1, "R9 idle after abort", 64'(rb[31]), 64'd1);
      chk(!mdc && !mdio_oe, "R9 pins low after abort", 64'({mdc, mdio_oe}), 64'd0);

      // recovery after abort
      run_access(1'b0, 5'h05, 5'h06, 16'h0, 16'h5A5A, 8'd2, 1'b0);

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule